// File: doc/BRIEF.md
# N-Phase Coherent Symbol Decision

This block sits behind a coherent demodulator and turns its baseband in-phase and quadrature samples into a symbol index for biphase, quadriphase or octaphase signalling. It forms up to four projections of the received vector. Every projection axis is perpendicular to one boundary between decision sectors. Each projection is summed over one symbol and then cleared.

When the external dump strobe arrives, the sign of each projection sum is taken against a zero threshold. Fixed logic maps the resulting pattern of sign bits to one of N sectors of equal width. The index is delivered Gray-coded together with a one-cycle valid pulse. The modulation order is chosen by a mode input that is captured only during reset.

Top module: `nphase_decider`

## Requirements
- R1: `mode_sel` is captured on every clock edge while `rst_n` is low and is ignored once reset is released. 2'b00 selects biphase, 2'b01 selects quadriphase, and 2'b10 or 2'b11 selects octaphase.
- R2: A clock edge with `rst_n` low (synchronous, active low) clears all four sums, drives `sym_vld` to 0 and drives `sym_gray` to 3'b000.
- R3: On every clock edge with `samp_vld` high, the projections of (`samp_i`, `samp_q`) are added to the sums. A sample that arrives with `samp_vld` low has no effect. A valid sample in the dump cycle belongs to the ending symbol. The next symbol starts from zero.
- R4: A clock edge with `dump` high loads a new `sym_gray`, and `sym_vld` is high for exactly the following cycle. In all other cycles `sym_vld` is low and `sym_gray` holds its value.
- R5: The four sums are P0 = ΣI, P1 = k(ΣI+ΣQ), P2 = ΣQ and P3 = k(ΣQ−ΣI). Here k is 1/√2 rounded to nearest with COEF_FRAC fractional bits. Each sign bit is 1 when its sum is zero or positive.
- R6: In biphase mode the index is 0 when P2 is non-negative and 1 otherwise. The I input has no effect.
- R7: In quadriphase mode the index comes from the signs of (P0, P2): (+,+)→0, (−,+)→1, (−,−)→2, (+,−)→3. P1 and P3 have no effect.
- R8: In octaphase mode the index comes from the sign pattern P0 P1 P2 P3: 1110→0, 1111→1, 0111→2, 0011→3, 0001→4, 0000→5, 1000→6, 1100→7.
- R9: `sym_gray` equals index XOR (index >> 1). Its two upper bits are 0 in biphase mode and its top bit is 0 in quadriphase mode.
- R10: The sums do not overflow when a symbol holds up to MAX_LEN samples of full-scale input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the mode is captured |
| mode_sel | input | 2 | Modulation order selection, captured during reset |
| samp_vld | input | 1 | Marks the current I/Q sample as part of the symbol |
| samp_i | input | SAMPLE_W | Signed in-phase sample |
| samp_q | input | SAMPLE_W | Signed quadrature sample |
| dump | input | 1 | End-of-symbol strobe |
| sym_gray | output | 3 | Gray-coded sector index |
| sym_vld | output | 1 | One-cycle pulse marking a new index |

## Verification
A decision is due at the same rising edge that samples `dump` high, so the bench drives the strobe on a falling edge and reads `sym_vld` and `sym_gray` at the next falling edge. One falling edge later it checks that the pulse has dropped and that the index is unchanged. Samples count from the edge that sees them, so the expected sums are updated in the bench whenever it drives a valid sample, including one driven together with `dump`. Mode changes are applied only after the reset edges have passed. This lets the bench show that a late change has no effect on the next decision.

// File: rtl/nphase_pkg.sv
package nphase_pkg;

  typedef enum logic [1:0] {
    MODE_BI   = 2'b00,
    MODE_QUAD = 2'b01,
    MODE_OCT  = 2'b10
  } mode_e;

  // number of projection lanes needed by the largest order (N/2 for N = 8)
  localparam int NPROJ = 4;

  // round(2^cf / sqrt(2)) = round(sqrt(2^(2cf-1)))
  function automatic int inv_sqrt2_coef(input int cf);
    longint target;
    longint root;
    target = longint'(1) << (2 * cf - 1);
    root   = 0;
    for (longint k = 0; k <= (longint'(1) << cf); k++) begin
      if (k * k <= target) root = k;
    end
    // (r + 0.5)^2 = r^2 + r + 0.25
    if (target - root * root > root) root = root + 1;
    return int'(root);
  endfunction

  function automatic logic [2:0] to_gray(input logic [2:0] bin);
    return bin ^ (bin >> 1);
  endfunction

  function automatic logic [2:0] count_set(input logic [3:0] s);
    return 3'(s[0]) + 3'(s[1]) + 3'(s[2]) + 3'(s[3]);
  endfunction

  // s[0]: I axis, s[1]: +45 deg axis, s[2]: Q axis, s[3]: +135 deg axis
  function automatic logic [2:0] sector_idx(input mode_e m, input logic [3:0] s);
    logic [2:0] ones;
    ones = count_set(s);
    case (m)
      MODE_BI:   return {2'b00, ~s[2]};
      MODE_QUAD: begin
        case ({s[0], s[2]})
          2'b11:   return 3'd0;
          2'b01:   return 3'd1;
          2'b00:   return 3'd2;
          default: return 3'd3;
        endcase
      end
      default: begin
        // the four signs form a Johnson pattern around the circle
        if (s[0]) return 3'(ones + 3'd5);
        else      return 3'(3'd5 - ones);
      end
    endcase
  endfunction

endpackage

// File: rtl/nphase_proj.sv
module nphase_proj
  import nphase_pkg::*;
#(
  parameter int W  = 8,
  parameter int CF = 10,
  parameter int PW = W + CF + 3
) (
  input  logic signed [W-1:0]  in_i,
  input  logic signed [W-1:0]  in_q,
  output logic signed [PW-1:0] proj [NPROJ]
);

  localparam int COEF = inv_sqrt2_coef(CF);
  localparam logic signed [CF+1:0] COEF_S = (CF + 2)'(COEF);

  logic signed [W:0] sum_iq;
  logic signed [W:0] dif_qi;

  assign sum_iq = (W + 1)'(in_i) + (W + 1)'(in_q);
  assign dif_qi = (W + 1)'(in_q) - (W + 1)'(in_i);

  // all lanes carry the same 2^CF scale so signs compare without truncation
  for (genvar k = 0; k < NPROJ; k++) begin : g_lane
    if (k == 0) begin : g_i
      assign proj[k] = PW'(in_i) <<< CF;
    end else if (k == 1) begin : g_diag
      assign proj[k] = PW'(sum_iq) * PW'(COEF_S);
    end else if (k == 2) begin : g_q
      assign proj[k] = PW'(in_q) <<< CF;
    end else begin : g_anti
      assign proj[k] = PW'(dif_qi) * PW'(COEF_S);
    end
  end

endmodule

// File: rtl/nphase_integ.sv
module nphase_integ #(
  parameter int PW = 21,
  parameter int AW = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld,
  input  logic                 dump,
  input  logic signed [PW-1:0] proj,
  output logic                 nonneg
);

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] acc_nxt;
  logic signed [AW-1:0] pext;

  assign pext    = AW'(proj);
  assign acc_nxt = vld ? acc + pext : acc;
  // zero threshold: zero counts as non-negative
  assign nonneg  = ~acc_nxt[AW-1];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (dump) acc <= '0;
    else           acc <= acc_nxt;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !dump && (acc[AW-1] == pext[AW-1])) |=> (acc[AW-1] == $past(acc[AW-1])));

  // R3
  dump_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump |=> (acc == '0));

endmodule

// File: rtl/nphase_sector.sv
module nphase_sector
  import nphase_pkg::*;
(
  input  mode_e            mode,
  input  logic [NPROJ-1:0] signs,
  output logic [2:0]       idx,
  output logic [2:0]       gray
);

  assign idx  = sector_idx(mode, signs);
  assign gray = to_gray(idx);

  // R9
  always_comb begin
    gray_map_chk: assert ((gray[2] == idx[2]) && (gray[1] == (idx[2] ^ idx[1])));
  end

endmodule

// File: rtl/nphase_decider.sv
module nphase_decider
  import nphase_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int COEF_FRAC = 10,
  parameter int MAX_LEN   = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode_sel,
  input  logic                       samp_vld,
  input  logic signed [SAMPLE_W-1:0] samp_i,
  input  logic signed [SAMPLE_W-1:0] samp_q,
  input  logic                       dump,
  output logic [2:0]                 sym_gray,
  output logic                       sym_vld
);

  localparam int PW = SAMPLE_W + COEF_FRAC + 3;
  localparam int AW = PW + $clog2(MAX_LEN + 1);

  mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_sel[1] ? MODE_OCT : mode_e'(mode_sel);
  end

  logic signed [PW-1:0] proj [NPROJ];
  logic [NPROJ-1:0]     signs;
  logic [2:0]           dec_idx;
  logic [2:0]           dec_gray;
  logic                 dump_fire;

  assign dump_fire = dump;

  nphase_proj #(.W(SAMPLE_W), .CF(COEF_FRAC), .PW(PW)) u_proj (
    .in_i (samp_i),
    .in_q (samp_q),
    .proj (proj)
  );

  for (genvar k = 0; k < NPROJ; k++) begin : g_int
    nphase_integ #(.PW(PW), .AW(AW)) u_integ (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld    (samp_vld),
      .dump   (dump_fire),
      .proj   (proj[k]),
      .nonneg (signs[k])
    );
  end

  nphase_sector u_sector (
    .mode  (mode_q),
    .signs (signs),
    .idx   (dec_idx),
    .gray  (dec_gray)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_gray <= 3'b000;
      sym_vld  <= 1'b0;
    end else begin
      sym_vld <= dump_fire;
      if (dump_fire) sym_gray <= dec_gray;
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dump_fire |=> sym_vld);

  // R4
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_fire |=> !sym_vld);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_fire |=> $stable(sym_gray));

  // R1
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q));

  // R6
  bi_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && (mode_q == MODE_BI)) |-> (sym_gray[2:1] == 2'b00));

  // R7
  quad_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld && (mode_q == MODE_QUAD)) |-> (sym_gray[2] == 1'b0));

endmodule

// File: tb/nphase_decider_test.sv
module nphase_decider_test;

  localparam int SW = 8;

  logic          clk;
  logic          rst_n;
  logic [1:0]    mode_sel;
  logic          samp_vld;
  logic signed [SW-1:0] samp_i;
  logic signed [SW-1:0] samp_q;
  logic          dump;
  logic [2:0]    sym_gray;
  logic          sym_vld;

  int n_chk  = 0;
  int n_fail = 0;
  int sum_i  = 0;
  int sum_q  = 0;
  int cur_mode = 0;

  nphase_decider #(.SAMPLE_W(SW), .COEF_FRAC(10), .MAX_LEN(64)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .samp_vld (samp_vld),
    .samp_i   (samp_i),
    .samp_q   (samp_q),
    .dump     (dump),
    .sym_gray (sym_gray),
    .sym_vld  (sym_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected Gray output restated from the sign tables
  function automatic int exp_gray(input int m, input int si, input int sq);
    bit b0, b1, b2, b3;
    int idx;
    b0 = (si >= 0);
    b1 = (si + sq >= 0);
    b2 = (sq >= 0);
    b3 = (sq - si >= 0);
    if (m == 0) idx = b2 ? 0 : 1;
    else if (m == 1) begin
      if (b0 && b2) idx = 0;
      else if (!b0 && b2) idx = 1;
      else if (!b0 && !b2) idx = 2;
      else idx = 3;
    end else begin
      case ({b0, b1, b2, b3})
        4'b1110: idx = 0;
        4'b1111: idx = 1;
        4'b0111: idx = 2;
        4'b0011: idx = 3;
        4'b0001: idx = 4;
        4'b0000: idx = 5;
        4'b1000: idx = 6;
        4'b1100: idx = 7;
        default: idx = -1;
      endcase
    end
    case (idx)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 2;
      4: return 6;
      5: return 7;
      6: return 5;
      7: return 4;
      default: return -1;
    endcase
  endfunction

  task automatic do_reset(input int m);
    @(negedge clk);
    rst_n = 1'b0; mode_sel = 2'(m); dump = 1'b0; samp_vld = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 reset valid", int'(sym_vld), 0);
    check("R2 reset index", int'(sym_gray), 0);
    rst_n = 1'b1;
    sum_i = 0; sum_q = 0;
    cur_mode = (m >= 2) ? 2 : m;
    mode_sel = ~2'(m);   // R1: changes after reset must be ignored
  endtask

  task automatic push(input int i, input int q);
    @(negedge clk);
    samp_vld = 1'b1; samp_i = SW'(i); samp_q = SW'(q);
    sum_i += i; sum_q += q;
  endtask

  task automatic push_idle(input int i, input int q);
    @(negedge clk);
    samp_vld = 1'b0; samp_i = SW'(i); samp_q = SW'(q);
  endtask

  task automatic finish_symbol(input string req, input bit ws, input int i, input int q);
    int exp;
    @(negedge clk);
    dump = 1'b1; samp_vld = ws; samp_i = SW'(i); samp_q = SW'(q);
    if (ws) begin sum_i += i; sum_q += q; end
    exp = exp_gray(cur_mode, sum_i, sum_q);
    @(negedge clk);
    dump = 1'b0; samp_vld = 1'b0;
    check("R4 valid after dump", int'(sym_vld), 1);
    check(req, int'(sym_gray), exp);
    sum_i = 0; sum_q = 0;
    @(negedge clk);
    check("R4 single pulse", int'(sym_vld), 0);
    check("R4 index held", int'(sym_gray), exp);
  endtask

  task automatic t_biphase();
    do_reset(0);
    push(50, 30); push(-90, 10);
    finish_symbol("R6 upper half", 0, 0, 0);
    push(100, -5);
    finish_symbol("R6 lower half", 0, 0, 0);
    push(-100, -20);
    finish_symbol("R6 negative I", 0, 0, 0);
    push(100, -20);
    finish_symbol("R6 I ignored", 0, 0, 0);
    push(-120, 3);
    finish_symbol("R9 biphase gray", 0, 0, 0);
  endtask

  task automatic t_quad();
    do_reset(1);
    push(60, 40); push_idle(-128, -128);
    finish_symbol("R7 quadrant 0 R3 idle ignored", 0, 0, 0);
    push(-60, 40);
    finish_symbol("R7 quadrant 1", 0, 0, 0);
    push(-60, -40);
    finish_symbol("R7 quadrant 2", 0, 0, 0);
    push(60, -40);
    finish_symbol("R7 quadrant 3 R9", 0, 0, 0);
    push(10, 100);
    finish_symbol("R7 diagonals ignored", 0, 0, 0);
  endtask

  task automatic t_octal();
    do_reset(2);
    push(100, 40);   finish_symbol("R8 sector 0", 0, 0, 0);
    push(40, 100);   finish_symbol("R8 sector 1", 0, 0, 0);
    push(-40, 100);  finish_symbol("R8 sector 2", 0, 0, 0);
    push(-100, 40);  finish_symbol("R8 sector 3", 0, 0, 0);
    push(-100, -40); finish_symbol("R8 sector 4 R9", 0, 0, 0);
    push(-40, -100); finish_symbol("R8 sector 5", 0, 0, 0);
    push(40, -100);  finish_symbol("R8 sector 6", 0, 0, 0);
    push(100, -40);  finish_symbol("R8 sector 7", 0, 0, 0);
    finish_symbol("R5 tie empty symbol", 0, 0, 0);
    push(50, 0);     finish_symbol("R5 tie on I axis", 0, 0, 0);
    push(50, 50);    finish_symbol("R5 tie on diagonal", 0, 0, 0);
    push(-50, -50);  finish_symbol("R5 tie on negative diagonal", 0, 0, 0);
  endtask

  task automatic t_integration();
    do_reset(2);
    push(-60, 20); push(-60, 20); push(100, 20);
    finish_symbol("R3 summed over symbol", 0, 0, 0);
    push(30, 30);
    finish_symbol("R3 dump-cycle sample", 1, -100, 10);
    push(10, -90);
    finish_symbol("R3 restart after dump", 0, 0, 0);
    push(20, 20); push_idle(-128, 0); push(20, -10);
    finish_symbol("R3 gap samples ignored", 0, 0, 0);
  endtask

  task automatic t_mode_latch();
    do_reset(3);
    push(-100, -40);
    finish_symbol("R1 mode held after reset", 0, 0, 0);
  endtask

  task automatic t_fullscale();
    do_reset(2);
    for (int n = 0; n < 64; n++) push(-128, -128);
    finish_symbol("R10 full negative", 0, 0, 0);
    for (int n = 0; n < 64; n++) push(127, 127);
    finish_symbol("R10 full positive", 0, 0, 0);
    for (int n = 0; n < 64; n++) push(127, -128);
    finish_symbol("R10 mixed full scale", 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; samp_vld = 1'b0;
    samp_i = '0; samp_q = '0; dump = 1'b0;
    t_biphase();
    t_quad();
    t_octal();
    t_integration();
    t_mode_latch();
    t_fullscale();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R4 watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule